// File: doc/BRIEF.md
# Concurrent-Write Shared Word Store

This block is a small register-file memory that several processor ports use in the same clock cycle. On every cycle each port may read one word and write one word. Reads are never restricted. Any number of ports may read the same word at the same time. Each port gets its read result on the next cycle.

When two or more ports write the same word in one cycle, a two-bit policy input decides the outcome. It is sampled on every cycle, so the policy can change from one cycle to the next. The four policies are:

- **Equal-value:** the write is committed only if all the colliding values agree.
- **Rotating pick:** one collider is chosen by a rotating pointer.
- **Ranked:** the lowest-numbered port wins.
- **Merge:** the word receives the combination of all colliding values. The default operator is the sum. A build parameter can select OR, AND or maximum instead.

Each port receives a per-cycle outcome code one cycle after its request. Writes to different words never interfere with each other.

Top module: `crcw_mem`

## Requirements
- R1: After reset, every word reads as zero and every outcome code is idle (2'b00).
- R2: `rd_data` for port i shows the word at that port's read address one cycle later. A write to the same word in the same cycle is not visible in that result; it appears from the following cycle.
- R3: A port's outcome code, valid one cycle after the request, is 2'b00 when it did not write, 2'b01 on success and 2'b10 on failure. The code 2'b11 never appears.
- R4: A port that is the only writer of its address in a cycle always succeeds, and the word takes its data, under every policy.
- R5: Policy 0 (equal-value): if all colliders present the same value, all succeed and the value is stored. Otherwise all fail and the word keeps its old value.
- R6: Policy 1 (rotating pick): exactly one collider succeeds, the others fail, and the word takes the winner's data.
- R7: Under policy 1, the pointer moves one step after every cycle that has a collision. Over four consecutive cycles in which all four ports collide, every port wins once.
- R8: Policy 2 (ranked): the lowest-indexed collider succeeds, the rest fail, and the word takes its data.
- R9: Policy 3 (merge): every collider succeeds, and the word receives the sum of all colliding values modulo 256.
- R10: The policy is taken from the `mode` input of the current cycle. The same collision resolves differently in back-to-back cycles when `mode` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Conflict policy: 0 equal-value, 1 rotating pick, 2 ranked, 3 merge |
| rd_addr | input | NPORT*AW | Read address per port, port i at bits [i*AW +: AW] |
| rd_data | output | NPORT*DW | Registered read data per port |
| wr_en | input | NPORT | Write request per port |
| wr_addr | input | NPORT*AW | Write address per port |
| wr_data | input | NPORT*DW | Write data per port |
| wr_status | output | NPORT*2 | Outcome code per port, port i at bits [2i +: 2] |

## Verification
The bench builds the block at its defaults: 4 ports, 16 words, 8-bit data, with the sum as the merge operator. Write addresses are drawn from a four-word window, so the sweep walks every pairing of ports onto shared or separate words. It covers every write-enable mask under every policy, with data that alternates between agreeing and disagreeing values. This reaches two-, three- and four-way collisions, and mixed cycles with several independent groups. It also exercises read-before-write on words that are being written in the same cycle.

// File: rtl/crcw_mem.sv
module crcw_mem #(
  parameter int NPORT   = 4,
  parameter int DEPTH   = 16,
  parameter int DW      = 8,
  parameter int COMB_OP = 0,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic [NPORT*AW-1:0] rd_addr,
  output logic [NPORT*DW-1:0] rd_data,
  input  logic [NPORT-1:0]    wr_en,
  input  logic [NPORT*AW-1:0] wr_addr,
  input  logic [NPORT*DW-1:0] wr_data,
  output logic [NPORT*2-1:0]  wr_status
);
  localparam logic [1:0] M_EQ = 2'd0, M_ARB = 2'd1, M_PRI = 2'd2, M_CMB = 2'd3;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [AW-1:0] wa [NPORT];
  logic [AW-1:0] ra [NPORT];
  logic [DW-1:0] wd [NPORT];
  logic [DW-1:0] val [NPORT];
  logic [NPORT-1:0] coll, lead, same, rbeat, succ;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (COMB_OP)
      1:       return a | b;
      2:       return a & b;
      3:       return (a > b) ? a : b;
      default: return a + b;
    endcase
  endfunction

  function automatic int rdist(input int j, input int p);
    return (j >= p) ? j - p : j + NPORT - p;
  endfunction

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      wa[i] = wr_addr[i*AW +: AW];
      ra[i] = rd_addr[i*AW +: AW];
      wd[i] = wr_data[i*DW +: DW];
    end
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      coll[i]  = 1'b0;
      lead[i]  = 1'b1;
      same[i]  = 1'b1;
      rbeat[i] = 1'b0;
      val[i]   = wd[i];
      for (int j = 0; j < NPORT; j++) begin
        if (j != i && wr_en[j] && wa[j] == wa[i]) begin
          coll[i] = 1'b1;
          if (j < i) lead[i] = 1'b0;
          if (wd[j] != wd[i]) same[i] = 1'b0;
          if (rdist(j, int'(ptr)) < rdist(i, int'(ptr))) rbeat[i] = 1'b1;
          val[i] = merge(val[i], wd[j]);
        end
      end
      case (mode)
        M_EQ:    succ[i] = wr_en[i] & same[i];
        M_ARB:   succ[i] = wr_en[i] & ~rbeat[i];
        M_PRI:   succ[i] = wr_en[i] & lead[i];
        default: succ[i] = wr_en[i];
      endcase
      if (mode != M_CMB) val[i] = wd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      rd_data   <= '0;
      wr_status <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        rd_data[i*DW +: DW] <= mem[ra[i]];
        wr_status[i*2 +: 2] <= !wr_en[i] ? 2'b00 : (succ[i] ? 2'b01 : 2'b10);
        if (succ[i] && (mode != M_CMB || lead[i])) mem[wa[i]] <= val[i];
      end
      if (mode == M_ARB && |(coll & wr_en))
        ptr <= (int'(ptr) == NPORT - 1) ? '0 : ptr + 1'b1;
    end
  end
endmodule

module crcw_mem_chk #(
  parameter int NPORT = 4,
  parameter int AW    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode,
  input logic [NPORT-1:0]    wr_en,
  input logic [NPORT*AW-1:0] wr_addr,
  input logic [NPORT*2-1:0]  wr_status
);
  logic [NPORT-1:0] won;
  logic all_same;

  always_comb begin
    all_same = 1'b1;
    for (int k = 0; k < NPORT; k++) begin
      won[k] = wr_status[2*k];
      if (wr_addr[k*AW +: AW] != wr_addr[AW-1:0]) all_same = 1'b0;
    end
  end

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[k] |=> wr_status[2*k +: 2] == 2'b00);
    assert_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[k] |=> (wr_status[2*k +: 2] == 2'b01 || wr_status[2*k +: 2] == 2'b10));
    assert_merge_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && wr_en[k]) |=> wr_status[2*k +: 2] == 2'b01);
  end

  assert_top_rank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && wr_en[0]) |=> wr_status[1:0] == 2'b01);
  assert_one_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && (&wr_en) && all_same) |=> $countones(won) == 1);
endmodule

bind crcw_mem crcw_mem_chk #(.NPORT(NPORT), .AW(AW)) u_chk (.*);

// File: tb/sim_crcw_mem.sv
module sim_crcw_mem;
  localparam int P = 4, A = 4, W = 8, D = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic [P*A-1:0] rd_addr = '0, wr_addr = '0;
  logic [P*W-1:0] rd_data, wr_data = '0;
  logic [P-1:0] wr_en = '0;
  logic [P*2-1:0] wr_status;

  crcw_mem u0 (.clk, .rst_n, .mode, .rd_addr, .rd_data, .wr_en, .wr_addr, .wr_data, .wr_status);

  always #5 clk = ~clk;

  int nvec = 0, nfail = 0;
  logic [W-1:0] refm [D];
  logic [A-1:0] ta [P];
  logic [A-1:0] tr [P];
  logic [W-1:0] td [P];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  task automatic step(input logic [1:0] m, input logic [P-1:0] en);
    logic [W-1:0] exp_rd [P];
    logic [P-1:0] grp;
    int cnt, wins, s, wj;
    bit eq;
    mode  = m;
    wr_en = en;
    for (int i = 0; i < P; i++) begin
      wr_addr[i*A +: A] = ta[i];
      rd_addr[i*A +: A] = tr[i];
      wr_data[i*W +: W] = td[i];
      exp_rd[i] = refm[tr[i]];
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < P; i++) begin
      chk(rd_data[i*W +: W] == exp_rd[i], "R2", rd_data[i*W +: W], exp_rd[i]);
      if (!en[i]) chk(wr_status[2*i +: 2] == 2'b00, "R3", wr_status[2*i +: 2], 0);
    end
    for (int i = 0; i < P; i++) begin
      if (!en[i]) continue;
      grp = '0;
      for (int j = 0; j < P; j++) if (en[j] && ta[j] == ta[i]) grp[j] = 1'b1;
      if (grp & ((P'(1) << i) - 1)) continue;
      cnt = $countones(grp);
      eq = 1'b1; s = 0; wins = 0; wj = i;
      for (int j = 0; j < P; j++) if (grp[j]) begin
        if (td[j] != td[i]) eq = 1'b0;
        s += td[j];
      end
      if (cnt == 1) begin
        chk(wr_status[2*i +: 2] == 2'b01, "R4", wr_status[2*i +: 2], 1);
        refm[ta[i]] = td[i];
      end else begin
        for (int j = 0; j < P; j++) if (grp[j]) begin
          case (m)
            2'd0: chk(wr_status[2*j +: 2] == (eq ? 2'b01 : 2'b10), "R5", wr_status[2*j +: 2], eq ? 1 : 2);
            2'd2: chk(wr_status[2*j +: 2] == ((j == i) ? 2'b01 : 2'b10), "R8", wr_status[2*j +: 2], (j == i) ? 1 : 2);
            2'd3: chk(wr_status[2*j +: 2] == 2'b01, "R9", wr_status[2*j +: 2], 1);
            default: begin
              chk(wr_status[2*j +: 2] == 2'b01 || wr_status[2*j +: 2] == 2'b10, "R6", wr_status[2*j +: 2], 1);
              if (wr_status[2*j +: 2] == 2'b01) begin wins++; wj = j; end
            end
          endcase
        end
        case (m)
          2'd0: if (eq) refm[ta[i]] = td[i];
          2'd1: begin
            chk(wins == 1, "R6", wins, 1);
            refm[ta[i]] = td[wj];
          end
          2'd2: refm[ta[i]] = td[i];
          default: refm[ta[i]] = W'(s);
        endcase
      end
    end
  endtask

  initial begin
    #(150000 * 10);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [P-1:0] winmask;
    logic [W-1:0] base;
    for (int k = 0; k < D; k++) refm[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(wr_status == '0, "R1", wr_status, 0);
    for (int r = 0; r < D / P; r++) begin
      for (int i = 0; i < P; i++) begin tr[i] = A'(r*P + i); ta[i] = '0; td[i] = '0; end
      step(2'd0, '0);
    end
    for (int r = 0; r < D / P; r++) begin
      for (int i = 0; i < P; i++) tr[i] = A'(r*P + i);
      step(2'd0, '0);
      for (int i = 0; i < P; i++) chk(rd_data[i*W +: W] == '0, "R1", rd_data[i*W +: W], 0);
    end

    for (int v = 0; v < 4 * 16 * 256; v++) begin
      base = W'(v * 29);
      for (int i = 0; i < P; i++) begin
        ta[i] = A'((((v / 3) % 4) << 2) | ((v / 64) >> (2*i)) % 4);
        tr[i] = (v % 2 == 1) ? ta[i] : A'((v * 5 + i * 3) % D);
        td[i] = ((v % 5) < 2) ? base : W'(base + i * 41 + 1);
      end
      step(2'(v % 4), 4'((v / 4) % 16));
    end

    winmask = '0;
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < P; i++) begin ta[i] = 4'd5; tr[i] = 4'd5; td[i] = W'(10 + i); end
      step(2'd1, 4'hF);
      for (int i = 0; i < P; i++) if (wr_status[2*i +: 2] == 2'b01) winmask[i] = 1'b1;
    end
    chk(winmask == 4'hF, "R7", winmask, 4'hF);

    for (int i = 0; i < P; i++) begin ta[i] = 4'd9; tr[i] = 4'd0; td[i] = W'(100 + i); end
    step(2'd2, 4'b0011);
    chk(wr_status[3:0] == 4'b1001, "R10", wr_status[3:0], 4'b1001);
    step(2'd0, 4'b0011);
    chk(wr_status[3:0] == 4'b1010, "R10", wr_status[3:0], 4'b1010);
    tr[0] = 4'd9;
    step(2'd0, '0);
    chk(rd_data[W-1:0] == 8'd100, "R10", rd_data[W-1:0], 100);

    finish_run();
  end
endmodule